// File: doc/BRIEF.md
# Parcel Boundary Decoder

This block looks at a fetch window of sixteen 16-bit parcels and works out where each instruction in it begins. Instructions are 1, 2, 4 or 8 parcels long. The length of each instruction comes from a 2-bit size code in the first parcel of that instruction. A caller supplies the parcel index where decoding starts. From there the block follows the chain of instruction lengths to the end of the window. It reports which parcels begin a complete instruction, the size code of each of those starts, how many instructions it found and how many parcels they cover.

An instruction whose length runs past the last parcel of the window is not counted as complete. Instead the block raises an incomplete flag, so that the fetch logic knows to carry that instruction into the next window. The decode path is purely combinational. A parameter either adds one output register stage or passes the results straight through.

Top module: `parcel_boundary_decoder`

## Requirements
- R1: The size code of parcel i is `window_i[16*i+1 : 16*i]`. Code 00 is a 1-parcel instruction, 01 is 2 parcels, 10 is 4 parcels and 11 is 8 parcels.
- R2: No parcel below `start_i` is ever marked as a start. If the instruction at `start_i` is complete, bit `start_i` of `start_mask_o` is set.
- R3: After a complete start at parcel p with length L, the next start is at parcel p+L. No parcel strictly between p and p+L is marked.
- R4: The size code of a parcel that is not reached by the chain has no effect on any output.
- R5: Field `len_code_o[2*i+1 : 2*i]` holds the size code of parcel i when bit i of `start_mask_o` is set, and holds 00 otherwise.
- R6: `consumed_o` equals the sum of the lengths of the complete instructions. Adding it to `start_i` never gives more than 16.
- R7: `incomplete_o` is 1 exactly when the last instruction of the chain extends past parcel 15. That instruction's start bit stays clear and its length is not added to `consumed_o`.
- R8: A chain that ends exactly at the window edge leaves `incomplete_o` at 0. In that case `consumed_o` is 16 minus `start_i`.
- R9: `inst_count_o` equals the number of set bits in `start_mask_o`.
- R10: With the default output register, the results for an input appear one clock cycle after that input. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| window_i | input | 256 | Sixteen parcels; parcel i occupies bits 16*i+15 down to 16*i |
| start_i | input | 4 | Index of the parcel where decoding begins |
| start_mask_o | output | 16 | Bit i set when parcel i begins a complete instruction |
| len_code_o | output | 32 | Size code of each start parcel; 00 where no start |
| consumed_o | output | 5 | Parcels covered by complete instructions, counted from `start_i` |
| inst_count_o | output | 5 | Number of complete instructions found |
| incomplete_o | output | 1 | The last instruction crosses the window edge |

## Verification
With the default output register, every result is due exactly one rising edge after its window and start index are applied. Reset forces all outputs to zero while `rst_n` is low.

The bench's driver changes the inputs on a falling edge. It queues the expected values from its own chain walk, tagged with the cycle number they are due in. The monitor compares the outputs only on the falling edge whose cycle number matches that tag. At the end, an empty queue confirms that no result was late or missing.

// File: rtl/bd_pkg.sv
`timescale 1ns/1ps
package bd_pkg;
  // Width of the size code carried in each parcel.
  localparam int unsigned SIZE_W = 2;
  // Number of distinct lengths and the longest one, in parcels.
  localparam int unsigned N_SIZES = 1 << SIZE_W;
  localparam int unsigned MAX_SPAN = 1 << (N_SIZES - 1);

  typedef enum logic [SIZE_W-1:0] {
    SZ_ONE   = 2'b00,
    SZ_TWO   = 2'b01,
    SZ_FOUR  = 2'b10,
    SZ_EIGHT = 2'b11
  } size_code_e;

  // Length in parcels encoded by a size code.
  function automatic int unsigned span_of(input logic [SIZE_W-1:0] code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/bd_chain.sv
`timescale 1ns/1ps
// Follows the chain of instruction starts across all lanes. A lane can only
// be reached from the lane 1, 2, 4 or 8 below it, so each lane needs only
// N_SIZES candidate links.
module bd_chain
  import bd_pkg::*;
#(
  parameter int unsigned LANES    = 16,
  parameter int unsigned PARCEL_W = 16,
  localparam int unsigned IDX_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*PARCEL_W-1:0] window_i,
  input  logic [IDX_W-1:0]          start_i,
  output logic [LANES*SIZE_W-1:0]   code_o,
  output logic [LANES-1:0]          done_o,
  output logic [LANES-1:0]          over_o
);
  logic [SIZE_W-1:0] code_a [LANES];
  logic [LANES-1:0]  hit_v;

  // Only the size code bits of each parcel are decoded here.
  logic unused_payload;
  assign unused_payload = ^window_i;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE_ID = IDX_W'(j);
    localparam int unsigned ROOM = LANES - j;
    logic [N_SIZES-1:0] link;

    assign code_a[j] = window_i[j*PARCEL_W +: SIZE_W];

    for (genvar k = 0; k < N_SIZES; k++) begin : g_span
      localparam int unsigned DIST = 1 << k;
      localparam logic [SIZE_W-1:0] KCODE = SIZE_W'(k);
      if (j >= DIST) begin : g_from
        assign link[k] = hit_v[j-DIST] && (code_a[j-DIST] == KCODE);
      end else begin : g_none
        assign link[k] = 1'b0;
      end
    end

    assign hit_v[j] = (start_i == LANE_ID) || (|link);

    if (ROOM >= MAX_SPAN) begin : g_roomy
      assign over_o[j] = 1'b0;
    end else begin : g_edge
      assign over_o[j] = hit_v[j] && (span_of(code_a[j]) > ROOM);
    end

    assign done_o[j] = hit_v[j] && !over_o[j];
    assign code_o[j*SIZE_W +: SIZE_W] = code_a[j];
  end
endmodule

// File: rtl/bd_summary.sv
`timescale 1ns/1ps
// Turns the per-lane chain result into the masked codes, the parcel total,
// the instruction count and the incomplete flag.
module bd_summary
  import bd_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES*SIZE_W-1:0] code_i,
  input  logic [LANES-1:0]        done_i,
  input  logic [LANES-1:0]        over_i,
  output logic [LANES*SIZE_W-1:0] len_code_o,
  output logic [CNT_W-1:0]        consumed_o,
  output logic [CNT_W-1:0]        count_o,
  output logic                    incomplete_o
);
  function automatic logic [CNT_W-1:0] total_span(
    input logic [LANES-1:0]        done,
    input logic [LANES*SIZE_W-1:0] codes
  );
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      if (done[i]) acc = acc + CNT_W'(span_of(codes[i*SIZE_W +: SIZE_W]));
    end
    return acc;
  endfunction

  function automatic logic [CNT_W-1:0] ones(input logic [LANES-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) acc = acc + CNT_W'(v[i]);
    return acc;
  endfunction

  for (genvar j = 0; j < LANES; j++) begin : g_mask
    assign len_code_o[j*SIZE_W +: SIZE_W] =
      done_i[j] ? code_i[j*SIZE_W +: SIZE_W] : '0;
  end

  assign consumed_o   = total_span(done_i, code_i);
  assign count_o      = ones(done_i);
  assign incomplete_o = |over_i;
endmodule

// File: rtl/bd_outreg.sv
`timescale 1ns/1ps
// Optional output stage: one register, or a plain pass-through.
module bd_outreg #(
  parameter int unsigned WIDTH  = 8,
  parameter bit          ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (ENABLE) begin : g_reg
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d_i;
    end
    assign q_o = q;
  end else begin : g_wire
    logic unused_ctl;
    assign unused_ctl = clk ^ rst_n;
    assign q_o = d_i;
  end
endmodule

// File: rtl/parcel_boundary_decoder.sv
`timescale 1ns/1ps
module parcel_boundary_decoder
  import bd_pkg::*;
#(
  parameter int unsigned LANES    = 16,
  parameter int unsigned PARCEL_W = 16,
  parameter bit          OUT_REG  = 1'b1,
  localparam int unsigned IDX_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned CNT_W   = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES*PARCEL_W-1:0] window_i,
  input  logic [IDX_W-1:0]          start_i,
  output logic [LANES-1:0]          start_mask_o,
  output logic [LANES*SIZE_W-1:0]   len_code_o,
  output logic [CNT_W-1:0]          consumed_o,
  output logic [CNT_W-1:0]          inst_count_o,
  output logic                      incomplete_o
);
  localparam int unsigned PACK_W = LANES*SIZE_W + LANES + 2*CNT_W + 1;

  // Named internal events, visible to the bound checker.
  logic [LANES*SIZE_W-1:0] chain_code;
  logic [LANES-1:0]        chain_done;
  logic [LANES-1:0]        chain_over;
  logic [LANES*SIZE_W-1:0] sum_codes;
  logic [CNT_W-1:0]        sum_consumed;
  logic [CNT_W-1:0]        sum_count;
  logic                    sum_incomplete;
  logic [PACK_W-1:0]       pack_d;
  logic [PACK_W-1:0]       pack_q;

  bd_chain #(
    .LANES    (LANES),
    .PARCEL_W (PARCEL_W)
  ) u_chain (
    .window_i (window_i),
    .start_i  (start_i),
    .code_o   (chain_code),
    .done_o   (chain_done),
    .over_o   (chain_over)
  );

  bd_summary #(
    .LANES (LANES)
  ) u_summary (
    .code_i       (chain_code),
    .done_i       (chain_done),
    .over_i       (chain_over),
    .len_code_o   (sum_codes),
    .consumed_o   (sum_consumed),
    .count_o      (sum_count),
    .incomplete_o (sum_incomplete)
  );

  assign pack_d = {sum_codes, chain_done, sum_consumed, sum_count, sum_incomplete};

  bd_outreg #(
    .WIDTH  (PACK_W),
    .ENABLE (OUT_REG)
  ) u_outreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pack_d),
    .q_o   (pack_q)
  );

  assign {len_code_o, start_mask_o, consumed_o, inst_count_o, incomplete_o} = pack_q;
endmodule

// File: rtl/parcel_boundary_decoder_chk.sv
`timescale 1ns/1ps
module parcel_boundary_decoder_chk #(
  parameter int unsigned LANES   = 16,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned CNT_W  = $clog2(LANES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [IDX_W-1:0]     start_i,
  input logic [LANES-1:0]     chain_done,
  input logic [LANES-1:0]     chain_over,
  input logic [CNT_W-1:0]     sum_consumed,
  input logic [LANES-1:0]     start_mask_o,
  input logic [2*LANES-1:0]   len_code_o,
  input logic [CNT_W-1:0]     consumed_o,
  input logic [CNT_W-1:0]     inst_count_o,
  input logic                 incomplete_o
);
  function automatic logic [LANES-1:0] below(input logic [IDX_W-1:0] s);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (i < int'(s));
    return m;
  endfunction

  function automatic logic [LANES-1:0] nonzero(input logic [2*LANES-1:0] c);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = |c[2*i +: 2];
    return m;
  endfunction

  // R2
  no_start_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_done & below(start_i)) == '0);

  // R5
  code_only_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nonzero(len_code_o) & ~start_mask_o) == '0);

  // R6
  consumed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sum_consumed) + int'(start_i)) <= int'(LANES));

  // R7
  single_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chain_over));

  // R7
  overrun_not_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_over & chain_done) == '0);

  // R9
  count_matches_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(inst_count_o) == $countones(start_mask_o));

  if (OUT_REG) begin : g_reg_chk
    // R10
    reset_clears_chk: assert property (@(posedge clk)
      !rst_n |-> (start_mask_o == '0 && len_code_o == '0 && consumed_o == '0
                  && inst_count_o == '0 && incomplete_o == 1'b0));
  end
endmodule

bind parcel_boundary_decoder parcel_boundary_decoder_chk #(
  .LANES   (LANES),
  .OUT_REG (OUT_REG)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .chain_done   (chain_done),
  .chain_over   (chain_over),
  .sum_consumed (sum_consumed),
  .start_mask_o (start_mask_o),
  .len_code_o   (len_code_o),
  .consumed_o   (consumed_o),
  .inst_count_o (inst_count_o),
  .incomplete_o (incomplete_o)
);

// File: tb/parcel_boundary_decoder_tb.sv
`timescale 1ns/1ps
module parcel_boundary_decoder_tb;
  localparam int LANES = 16;
  localparam int PW    = 16;
  localparam int CW    = 5;

  logic                  clk   = 1'b0;
  logic                  rst_n = 1'b0;
  logic [LANES*PW-1:0]   win   = '0;
  logic [3:0]            st    = '0;
  logic [LANES-1:0]      mask;
  logic [2*LANES-1:0]    lc;
  logic [CW-1:0]         cons;
  logic [CW-1:0]         cnt;
  logic                  inc;

  always #5 clk = ~clk;

  parcel_boundary_decoder u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .window_i     (win),
    .start_i      (st),
    .start_mask_o (mask),
    .len_code_o   (lc),
    .consumed_o   (cons),
    .inst_count_o (cnt),
    .incomplete_o (inc)
  );

  typedef struct {
    logic [15:0] mask;
    logic [31:0] lc;
    int          cons;
    logic        inc;
    int          cnt;
    int          due;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          cyc    = 0;
  int          checks = 0;
  int          fails  = 0;
  logic [31:0] rng    = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] r);
    logic [31:0] x;
    x = r;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Size code of lane i goes in bits [1:0] of parcel i; the rest is filler.
  function automatic logic [255:0] build(input logic [31:0] codes, input logic [31:0] seed);
    logic [255:0] w;
    logic [31:0]  r;
    r = seed;
    for (int i = 0; i < 16; i++) begin
      r = step(r);
      w[i*16 +: 16] = {r[13:0], codes[i*2 +: 2]};
    end
    return w;
  endfunction

  // Walk the chain instruction by instruction from the start parcel.
  function automatic exp_t model(input logic [255:0] w, input int s, input string tag);
    exp_t e;
    int   p;
    int   span;
    e.mask = '0; e.lc = '0; e.cons = 0; e.inc = 1'b0; e.cnt = 0; e.due = 0; e.tag = tag;
    p = s;
    while (p < 16) begin
      span = 1 << int'(w[p*16 +: 2]);
      if (p + span > 16) begin
        e.inc = 1'b1;
        break;
      end
      e.mask[p]       = 1'b1;
      e.lc[p*2 +: 2]  = w[p*16 +: 2];
      e.cons         += span;
      e.cnt++;
      p += span;
    end
    return e;
  endfunction

  task automatic drive(input logic [255:0] w, input int s, input string tag);
    exp_t e;
    @(negedge clk);
    win = w;
    st  = 4'(s);
    e = model(w, s, tag);
    e.due = cyc + 1;
    sb.push_back(e);
  endtask

  // Monitor: results are due one rising edge after their stimulus.
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      e = sb.pop_front();
      check(e.tag, "start_mask", 32'(mask), 32'(e.mask));
      check(e.tag, "len_code",   lc,        e.lc);
      check(e.tag, "consumed",   32'(cons), 32'(e.cons));
      check(e.tag, "incomplete", 32'(inc),  32'(e.inc));
      check(e.tag, "count",      32'(cnt),  32'(e.cnt));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "mask@reset",  32'(mask), 32'h0);
    check("R10", "code@reset",  lc,        32'h0);
    check("R10", "cons@reset",  32'(cons), 32'h0);
    check("R10", "count@reset", 32'(cnt),  32'h0);
    check("R10", "inc@reset",   32'(inc),  32'h0);
    rst_n = 1'b1;

    drive(build(32'h5555_5555, 32'h0000_0011), 0,  "R1 R3 R8 all-two");
    drive(build(32'h0000_0000, 32'h0000_0022), 0,  "R1 R9 all-one");
    drive(build(32'hFFFF_FFFF, 32'h0000_0033), 0,  "R1 R3 all-eight");
    drive(build(32'hFFFF_FFFF, 32'h0000_0044), 1,  "R6 R7 eight-offset");
    drive(build(32'hAAAA_AAAA, 32'h0000_0055), 2,  "R1 R7 four-offset");
    drive(build(32'hDDDD_DDDD, 32'h0000_0066), 0,  "R4 skipped-lanes-ignored");
    drive(build(32'h5555_5555, 32'h0000_0077), 3,  "R2 R7 start3");
    drive(build(32'h5555_5555, 32'h0000_0088), 8,  "R2 R5 start8");
    drive(build(32'h0000_0000, 32'h0000_0099), 15, "R8 last-lane");
    drive(build(32'h4000_0000, 32'h0000_00AA), 15, "R7 lone-overrun");
    drive(build(32'h37FF_FCFE, 32'h0000_00BB), 0,  "R3 R4 R8 mixed");

    for (int n = 0; n < 300; n++) begin
      rng = step(rng);
      drive(build(rng, rng ^ 32'h9E37_79B9), int'(rng[3:0] ^ rng[19:16]),
            "R1 R3 R5 R6 R7 R9 random");
    end

    repeat (3) @(negedge clk);
    // R10: every queued result arrived in its due cycle
    check("R10", "pending", 32'(sb.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule